// File: doc/BRIEF.md
# Paired Non-Temporal Load Unit

This unit executes one kind of instruction: a load of two adjacent data elements into two general registers. It accepts a 32-bit instruction word through a valid/ready handshake and checks that the word has the expected fixed encoding. It then reads the base register, or the stack pointer when the base field is 31. It adds a signed 7-bit immediate, scaled by the element size, to form the first address. It issues two memory reads, one after the other, for two 32-bit words or two 64-bit doublewords. Once both reads have returned without error, it writes the two results into the two destination registers.

Some cases end in a one-cycle exception pulse instead of memory traffic:
- a word that is not this instruction;
- the reserved size encoding;
- two identical destinations;
- a misaligned stack-pointer base.

A memory error on either read also ends in an exception. In every one of these cases no register is written. The base register is never updated. The number of cycles depends only on the memory handshake and never on the loaded values.

Top module: `pairld_unit`

## Requirements
- R1: After reset the unit is idle: insn_ready is 1, and mem_req, rf_we, exc_valid and op_done are all 0.
- R2: A word is accepted as this instruction only when bits 29:23 equal 7'b1010000 and bit 22 is 1. Any other word gives exc_valid with exc_code 1 (undefined) in the cycle after acceptance, with no memory read and no register write.
- R3: When instruction bit 30 is 1 (sizes 01 and 11), the unit gives exc_code 1 with no memory read and no register write.
- R4: When bits 4:0 equal bits 14:10 (same destination), the unit gives exc_code 1 with no memory read and no register write.
- R5: Bit 31 selects the size: 0 means 4-byte elements (mem_size 0) and 1 means 8-byte elements (mem_size 1). The first read address is the base plus imm7 (bits 21:15), sign-extended and shifted left by 2 or 3. This gives a range of -256..252 or -512..504.
- R6: The second read follows the first and uses the first address plus 4 or 8.
- R7: A base field (bits 9:5) of 31 selects sp_value instead of general register 31. If sp_value bits 3:0 are not zero, the unit gives exc_code 2 with no memory read and no register write.
- R8: The first read result is written to the register in bits 4:0, then the second result to the register in bits 14:10, on consecutive cycles; op_done is 1 with the second write. For 4-byte elements, mem_rdata bits 31:0 are zero-extended to 64 bits.
- R9: If mem_err is 1 with mem_ack on either read, the unit gives exc_code 3 in the next cycle and writes no register.
- R10: With zero-wait memory, a successful instruction takes exactly 4 cycles after acceptance: two read cycles and two write cycles. Latency does not change with the loaded data.
- R11: insn_ready is 0 from acceptance until the instruction finishes. Only the two destination registers are written, and the base register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Unit idle and accepting |
| insn_word | input | 32 | Instruction word |
| sp_value | input | 64 | Current stack pointer |
| rf_rd_addr | output | 5 | Register-file read index (base field) |
| rf_rd_data | input | 64 | Register-file read data, combinational |
| rf_we | output | 1 | Register write enable |
| rf_wa | output | 5 | Register write index |
| rf_wd | output | 64 | Register write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 64 | Memory byte address |
| mem_size | output | 1 | 0 = 4 bytes, 1 = 8 bytes |
| mem_ack | input | 1 | Read completes this cycle |
| mem_rdata | input | 64 | Read data |
| mem_err | input | 1 | Read failed (valid with mem_ack) |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 2 | 1 undefined, 2 stack misaligned, 3 memory fault |
| op_done | output | 1 | Successful completion pulse |

## Verification
The stimulus uses both element sizes. Offsets run over zero, small positive, minus one, and the most negative and most positive encodings, which separates the 2-bit and 3-bit shifts and checks sign extension at both ends. Bases from a general register and from an aligned stack pointer tell apart register 31 and the stack pointer. Malformed words, reserved sizes, equal destinations and a misaligned stack pointer each have to produce their own exception code with no memory traffic. Errors injected on the first and then the second read, and a repeated instruction whose memory returns different data, show that no partial write occurs and that the cycle count is the same whatever the data.

// File: rtl/pairld_pkg.sv
package pairld_pkg;

   typedef enum logic [1:0] {
      EXC_NONE      = 2'd0,
      EXC_UNDEF     = 2'd1,
      EXC_SP_ALIGN  = 2'd2,
      EXC_MEM_FAULT = 2'd3
   } exc_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_LO,
      ST_RD_HI,
      ST_WR_LO,
      ST_WR_HI,
      ST_FAULT
   } state_e;

endpackage

// File: rtl/pairld_decode.sv
module pairld_decode #(
   parameter int unsigned INSN_W = 32,
   parameter int unsigned IMM_W  = 7,
   parameter int unsigned REG_AW = 5
) (
   input  logic [INSN_W-1:0] insn,
   output logic              dword,
   output logic [IMM_W-1:0]  imm,
   output logic [REG_AW-1:0] rt,
   output logic [REG_AW-1:0] rt2,
   output logic [REG_AW-1:0] rn,
   output logic              undef
);
   localparam int unsigned RN_LSB    = REG_AW;
   localparam int unsigned RT2_LSB   = 2 * REG_AW;
   localparam int unsigned IMM_LSB   = 3 * REG_AW;
   localparam int unsigned LOAD_BIT  = IMM_LSB + IMM_W;
   localparam int unsigned FIXED_LSB = LOAD_BIT + 1;
   localparam int unsigned FIXED_W   = 7;
   localparam int unsigned OPC_LSB   = FIXED_LSB + FIXED_W;
   localparam logic [FIXED_W-1:0] FIXED_PAT = 7'b1010000;

   if (OPC_LSB + 2 != INSN_W) begin : g_bad_layout
      $error("pairld_decode: field layout does not fill the instruction word");
   end

   logic match;

   always_comb begin
      rt    = insn[0 +: REG_AW];
      rn    = insn[RN_LSB +: REG_AW];
      rt2   = insn[RT2_LSB +: REG_AW];
      imm   = insn[IMM_LSB +: IMM_W];
      dword = insn[OPC_LSB + 1];
      match = (insn[FIXED_LSB +: FIXED_W] == FIXED_PAT) && insn[LOAD_BIT];
      undef = !match || insn[OPC_LSB] || (rt == rt2);
   end

endmodule

// File: rtl/pairld_agen.sv
module pairld_agen #(
   parameter int unsigned XLEN          = 64,
   parameter int unsigned IMM_W         = 7,
   parameter int unsigned REG_AW        = 5,
   parameter int unsigned SP_ALIGN_BITS = 4,
   parameter bit          SP_CHECK      = 1'b1
) (
   input  logic [REG_AW-1:0] rn,
   input  logic [XLEN-1:0]   gpr_val,
   input  logic [XLEN-1:0]   sp_val,
   input  logic [IMM_W-1:0]  imm,
   input  logic              dword,
   output logic [XLEN-1:0]   addr,
   output logic              sp_fault
);
   localparam logic [REG_AW-1:0] SP_IDX = '1;

   if (SP_ALIGN_BITS < 1 || SP_ALIGN_BITS >= XLEN) begin : g_bad_align
      $error("pairld_agen: SP_ALIGN_BITS out of range");
   end
   if (IMM_W + 3 >= XLEN) begin : g_bad_imm
      $error("pairld_agen: immediate too wide for XLEN");
   end

   logic            use_sp;
   logic [XLEN-1:0] base;
   logic [XLEN-1:0] imm_sx;
   logic [XLEN-1:0] offset;

   always_comb begin
      use_sp = (rn == SP_IDX);
      base   = use_sp ? sp_val : gpr_val;
      imm_sx = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
      offset = dword ? (imm_sx << 3) : (imm_sx << 2);
      addr   = base + offset;
   end

   if (SP_CHECK) begin : g_sp_check
      assign sp_fault = use_sp && (|sp_val[SP_ALIGN_BITS-1:0]);
   end else begin : g_no_sp_check
      assign sp_fault = 1'b0;
   end

endmodule

// File: rtl/pairld_seq.sv
module pairld_seq
   import pairld_pkg::*;
#(
   parameter int unsigned XLEN   = 64,
   parameter int unsigned REG_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_valid,
   output logic              insn_ready,
   input  logic              dec_undef,
   input  logic              dec_dword,
   input  logic [REG_AW-1:0] dec_rt,
   input  logic [REG_AW-1:0] dec_rt2,
   input  logic              sp_fault,
   input  logic [XLEN-1:0]   addr1,
   output logic              mem_req,
   output logic [XLEN-1:0]   mem_addr,
   output logic              mem_size,
   input  logic              mem_ack,
   input  logic [XLEN-1:0]   mem_rdata,
   input  logic              mem_err,
   output logic              rf_we,
   output logic [REG_AW-1:0] rf_wa,
   output logic [XLEN-1:0]   rf_wd,
   output logic              exc_valid,
   output logic [1:0]        exc_code,
   output logic              op_done
);
   localparam int unsigned WORD_W = 32;
   localparam logic [XLEN-1:0] WORD_BYTES  = XLEN'(4);
   localparam logic [XLEN-1:0] DWORD_BYTES = XLEN'(8);

   if (XLEN < 64) begin : g_bad_xlen
      $error("pairld_seq: XLEN must hold a doubleword");
   end

   state_e            state_q;
   logic [XLEN-1:0]   addr_q;
   logic              dword_q;
   logic [REG_AW-1:0] rt_q, rt2_q;
   logic [XLEN-1:0]   d_lo_q, d_hi_q;
   exc_e              exc_q;
   logic [XLEN-1:0]   rd_val;
   logic              accept;

   always_comb begin
      accept = insn_valid && (state_q == ST_IDLE);
      rd_val = dword_q ? mem_rdata : {{(XLEN-WORD_W){1'b0}}, mem_rdata[WORD_W-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         dword_q <= 1'b0;
         rt_q    <= '0;
         rt2_q   <= '0;
         d_lo_q  <= '0;
         d_hi_q  <= '0;
         exc_q   <= EXC_NONE;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               dword_q <= dec_dword;
               rt_q    <= dec_rt;
               rt2_q   <= dec_rt2;
               addr_q  <= addr1;
               if (dec_undef) begin
                  exc_q   <= EXC_UNDEF;
                  state_q <= ST_FAULT;
               end else if (sp_fault) begin
                  exc_q   <= EXC_SP_ALIGN;
                  state_q <= ST_FAULT;
               end else begin
                  state_q <= ST_RD_LO;
               end
            end
            ST_RD_LO: if (mem_ack) begin
               if (mem_err) begin
                  exc_q   <= EXC_MEM_FAULT;
                  state_q <= ST_FAULT;
               end else begin
                  d_lo_q  <= rd_val;
                  addr_q  <= addr_q + (dword_q ? DWORD_BYTES : WORD_BYTES);
                  state_q <= ST_RD_HI;
               end
            end
            ST_RD_HI: if (mem_ack) begin
               if (mem_err) begin
                  exc_q   <= EXC_MEM_FAULT;
                  state_q <= ST_FAULT;
               end else begin
                  d_hi_q  <= rd_val;
                  state_q <= ST_WR_LO;
               end
            end
            ST_WR_LO: state_q <= ST_WR_HI;
            ST_WR_HI: state_q <= ST_IDLE;
            ST_FAULT: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      insn_ready = (state_q == ST_IDLE);
      mem_req    = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
      mem_addr   = addr_q;
      mem_size   = dword_q;
      rf_we      = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
      rf_wa      = (state_q == ST_WR_HI) ? rt2_q : rt_q;
      rf_wd      = (state_q == ST_WR_HI) ? d_hi_q : d_lo_q;
      op_done    = (state_q == ST_WR_HI);
      exc_valid  = (state_q == ST_FAULT);
      exc_code   = exc_valid ? exc_q : EXC_NONE;
   end

   // R2
   undef_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_ready && dec_undef) |=>
         (exc_valid && exc_code == EXC_UNDEF && !mem_req && !rf_we));

   // R7
   sp_align_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_ready && !dec_undef && sp_fault) |=>
         (exc_valid && exc_code == EXC_SP_ALIGN && !mem_req));

   // R6
   second_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RD_LO && mem_ack && !mem_err) |=>
         (mem_req && mem_addr == $past(mem_addr) + (mem_size ? DWORD_BYTES : WORD_BYTES)));

   // R9
   mem_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_err) |=>
         (exc_valid && exc_code == EXC_MEM_FAULT && !rf_we));

   // R8
   pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rf_we) |=> (rf_we && op_done && rf_wa == $past(rt2_q)));

   // R11
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req || rf_we || exc_valid) |-> !insn_ready);

endmodule

// File: rtl/pairld_unit.sv
module pairld_unit #(
   parameter int unsigned XLEN          = 64,
   parameter int unsigned INSN_W        = 32,
   parameter int unsigned SP_ALIGN_BITS = 4,
   parameter bit          SP_CHECK      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_valid,
   output logic              insn_ready,
   input  logic [INSN_W-1:0] insn_word,
   input  logic [XLEN-1:0]   sp_value,
   output logic [4:0]        rf_rd_addr,
   input  logic [XLEN-1:0]   rf_rd_data,
   output logic              rf_we,
   output logic [4:0]        rf_wa,
   output logic [XLEN-1:0]   rf_wd,
   output logic              mem_req,
   output logic [XLEN-1:0]   mem_addr,
   output logic              mem_size,
   input  logic              mem_ack,
   input  logic [XLEN-1:0]   mem_rdata,
   input  logic              mem_err,
   output logic              exc_valid,
   output logic [1:0]        exc_code,
   output logic              op_done
);
   localparam int unsigned REG_AW = 5;
   localparam int unsigned IMM_W  = 7;

   logic              dec_dword, dec_undef, sp_fault;
   logic [IMM_W-1:0]  dec_imm;
   logic [REG_AW-1:0] dec_rt, dec_rt2, dec_rn;
   logic [XLEN-1:0]   addr1;

   pairld_decode #(.INSN_W(INSN_W), .IMM_W(IMM_W), .REG_AW(REG_AW)) u_decode (
      .insn  (insn_word),
      .dword (dec_dword),
      .imm   (dec_imm),
      .rt    (dec_rt),
      .rt2   (dec_rt2),
      .rn    (dec_rn),
      .undef (dec_undef)
   );

   assign rf_rd_addr = dec_rn;

   pairld_agen #(
      .XLEN(XLEN), .IMM_W(IMM_W), .REG_AW(REG_AW),
      .SP_ALIGN_BITS(SP_ALIGN_BITS), .SP_CHECK(SP_CHECK)
   ) u_agen (
      .rn       (dec_rn),
      .gpr_val  (rf_rd_data),
      .sp_val   (sp_value),
      .imm      (dec_imm),
      .dword    (dec_dword),
      .addr     (addr1),
      .sp_fault (sp_fault)
   );

   pairld_seq #(.XLEN(XLEN), .REG_AW(REG_AW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .insn_valid (insn_valid),
      .insn_ready (insn_ready),
      .dec_undef  (dec_undef),
      .dec_dword  (dec_dword),
      .dec_rt     (dec_rt),
      .dec_rt2    (dec_rt2),
      .sp_fault   (sp_fault),
      .addr1      (addr1),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_size   (mem_size),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .mem_err    (mem_err),
      .rf_we      (rf_we),
      .rf_wa      (rf_wa),
      .rf_wd      (rf_wd),
      .exc_valid  (exc_valid),
      .exc_code   (exc_code),
      .op_done    (op_done)
   );

endmodule

// File: tb/pairld_unit_tb.sv
module pairld_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic        insn_ready;
   logic [31:0] insn_word = '0;
   logic [63:0] sp_value = '0;
   logic [4:0]  rf_rd_addr;
   logic [63:0] rf_rd_data;
   logic        rf_we;
   logic [4:0]  rf_wa;
   logic [63:0] rf_wd;
   logic        mem_req;
   logic [63:0] mem_addr;
   logic        mem_size;
   logic        mem_ack;
   logic [63:0] mem_rdata;
   logic        mem_err;
   logic        exc_valid;
   logic [1:0]  exc_code;
   logic        op_done;

   int checks = 0;
   int errors = 0;

   logic [63:0] regs [32];
   logic [63:0] key = 64'h0123_4567_89AB_CDEF;
   logic        err_arm = 1'b0;
   logic [63:0] err_addr = '0;

   always #4 clk = ~clk;

   pairld_unit u_dut (.*);

   function automatic logic [63:0] mem_fn(input logic [63:0] a, input logic [63:0] k);
      return (a * 64'h9E37_79B9_7F4A_7C15) ^ k;
   endfunction

   assign rf_rd_data = regs[rf_rd_addr];
   assign mem_ack    = mem_req;
   assign mem_rdata  = mem_fn(mem_addr, key);
   assign mem_err    = mem_req && err_arm && (mem_addr == err_addr);

   always_ff @(posedge clk) if (rf_we) regs[rf_wa] <= rf_wd;

   typedef struct packed {
      logic [1:0]  opc;
      logic [6:0]  imm;
      logic [4:0]  rt2;
      logic [4:0]  rn;
      logic [4:0]  rt;
      logic        corrupt;
      logic [63:0] sp;
   } vec_t;

   localparam int NVEC = 11;
   localparam vec_t VECS [NVEC] = '{
      '{2'b00, 7'h01, 5'd2,  5'd5,  5'd1,  1'b0, 64'h0000_0000_0000_2000},
      '{2'b10, 7'h7F, 5'd4,  5'd6,  5'd3,  1'b0, 64'h0000_0000_0000_2000},
      '{2'b00, 7'h40, 5'd11, 5'd7,  5'd10, 1'b0, 64'h0000_0000_0000_2000},
      '{2'b10, 7'h3F, 5'd13, 5'd31, 5'd12, 1'b0, 64'h0000_0000_0000_1000},
      '{2'b10, 7'h00, 5'd15, 5'd31, 5'd14, 1'b0, 64'h0000_0000_0000_1008},
      '{2'b01, 7'h02, 5'd17, 5'd5,  5'd16, 1'b0, 64'h0000_0000_0000_2000},
      '{2'b11, 7'h02, 5'd19, 5'd5,  5'd18, 1'b0, 64'h0000_0000_0000_2000},
      '{2'b10, 7'h05, 5'd20, 5'd5,  5'd20, 1'b0, 64'h0000_0000_0000_2000},
      '{2'b00, 7'h05, 5'd22, 5'd5,  5'd21, 1'b1, 64'h0000_0000_0000_2000},
      '{2'b00, 7'h41, 5'd31, 5'd31, 5'd0,  1'b0, 64'h0000_0000_0000_3000},
      '{2'b00, 7'h00, 5'd9,  5'd8,  5'd8,  1'b0, 64'h0000_0000_0000_2000}
   };

   int          g_reads, g_writes, g_cycles;
   logic [63:0] g_raddr [2];
   logic        g_rsize;
   logic [4:0]  g_wa [2];
   logic [63:0] g_wd [2];
   logic [1:0]  g_code;
   logic        g_ready_bad;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_insn(input vec_t v);
      logic [31:0] w;
      w = {v.opc, 3'b101, 1'b0, 3'b000, 1'b1, v.imm, v.rt2, v.rn, v.rt};
      if (v.corrupt) w[26] = 1'b1;
      return w;
   endfunction

   task automatic run(input logic [31:0] insn, input logic [63:0] sp);
      g_reads = 0; g_writes = 0; g_cycles = 0; g_code = 2'd0; g_ready_bad = 1'b0;
      g_raddr[0] = '0; g_raddr[1] = '0; g_wa[0] = '0; g_wa[1] = '0; g_wd[0] = '0; g_wd[1] = '0;
      g_rsize = 1'b0;
      @(negedge clk);
      insn_word = insn; sp_value = sp; insn_valid = 1'b1;
      @(negedge clk);
      insn_valid = 1'b0;
      for (int c = 0; c < 12; c++) begin
         g_cycles++;
         if (insn_ready) g_ready_bad = 1'b1;
         if (mem_req) begin
            if (g_reads < 2) g_raddr[g_reads] = mem_addr;
            g_rsize = mem_size;
            g_reads++;
         end
         if (rf_we) begin
            if (g_writes < 2) begin g_wa[g_writes] = rf_wa; g_wd[g_writes] = rf_wd; end
            g_writes++;
         end
         if (exc_valid) begin g_code = exc_code; break; end
         if (op_done) break;
         @(negedge clk);
      end
   endtask

   task automatic check_vec(input vec_t v, input string tag);
      logic [31:0] insn;
      logic        undef, align, dw;
      logic [63:0] base, off, a1, a2, e1, e2, base_before;
      logic [1:0]  ecode;
      insn  = mk_insn(v);
      undef = v.corrupt || v.opc[0] || (v.rt == v.rt2);
      align = !undef && (v.rn == 5'd31) && (v.sp[3:0] != 4'h0);
      dw    = v.opc[1];
      base  = (v.rn == 5'd31) ? v.sp : regs[v.rn];
      base_before = regs[v.rn];
      off   = {{57{v.imm[6]}}, v.imm} << (dw ? 3 : 2);
      a1    = base + off;
      a2    = a1 + (dw ? 64'd8 : 64'd4);
      e1    = dw ? mem_fn(a1, key) : {32'h0, mem_fn(a1, key)[31:0]};
      e2    = dw ? mem_fn(a2, key) : {32'h0, mem_fn(a2, key)[31:0]};
      ecode = undef ? 2'd1 : (align ? 2'd2 : 2'd0);
      run(insn, v.sp);
      chk(g_code == ecode, {tag, " R2/R3/R4/R7 exception code"}, 64'(g_code), 64'(ecode));
      chk(!g_ready_bad, {tag, " R11 ready low while busy"}, 64'(g_ready_bad), 64'd0);
      if (ecode != 2'd0) begin
         chk(g_reads == 0 && g_writes == 0, {tag, " R3 no access on fault"},
             64'(g_reads + g_writes), 64'd0);
         chk(g_cycles == 1, {tag, " R2 fault next cycle"}, 64'(g_cycles), 64'd1);
      end else begin
         chk(g_reads == 2, {tag, " R6 two reads"}, 64'(g_reads), 64'd2);
         chk(g_raddr[0] == a1, {tag, " R5 first address"}, g_raddr[0], a1);
         chk(g_raddr[1] == a2, {tag, " R6 second address"}, g_raddr[1], a2);
         chk(g_rsize == dw, {tag, " R5 mem_size"}, 64'(g_rsize), 64'(dw));
         chk(g_writes == 2 && g_wa[0] == v.rt && g_wa[1] == v.rt2, {tag, " R8 write order"},
             {g_wa[0], g_wa[1]}, {v.rt, v.rt2});
         chk(g_wd[0] == e1, {tag, " R8 first data"}, g_wd[0], e1);
         chk(g_wd[1] == e2, {tag, " R8 second data"}, g_wd[1], e2);
         chk(g_cycles == 4, {tag, " R10 latency"}, 64'(g_cycles), 64'd4);
         @(negedge clk);
         if (v.rn != v.rt && v.rn != v.rt2 && v.rn != 5'd31)
            chk(regs[v.rn] == base_before, {tag, " R11 base unchanged"}, regs[v.rn], base_before);
      end
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      vec_t v;
      logic [63:0] a1;
      int lat0;
      for (int i = 0; i < 32; i++) regs[i] = 64'h0000_0040_0000_0000 + 64'(i) * 64'h1_0000;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(insn_ready && !mem_req && !rf_we && !exc_valid && !op_done, "R1 reset idle",
          {59'h0, insn_ready, mem_req, rf_we, exc_valid, op_done}, 64'h10);
      rst_n = 1'b1;
      @(negedge clk);
      chk(insn_ready && !mem_req && !rf_we, "R1 idle after reset", 64'(insn_ready), 64'd1);

      for (int i = 0; i < NVEC; i++) begin
         check_vec(VECS[i], $sformatf("vec%0d", i));
      end

      // R9 error on first read
      v = VECS[1];
      a1 = regs[v.rn] - 64'd8;
      err_arm = 1'b1; err_addr = a1;
      run(mk_insn(v), v.sp);
      chk(g_code == 2'd3, "R9 fault on first read code", 64'(g_code), 64'd3);
      chk(g_reads == 1 && g_writes == 0, "R9 first read fault no write",
          64'(g_reads * 10 + g_writes), 64'd10);
      // R9 error on second read
      err_addr = a1 + 64'd8;
      run(mk_insn(v), v.sp);
      chk(g_code == 2'd3, "R9 fault on second read code", 64'(g_code), 64'd3);
      chk(g_reads == 2 && g_writes == 0 && g_cycles == 3, "R9 second read fault no write",
          64'(g_reads * 100 + g_writes * 10 + g_cycles), 64'd203);
      err_arm = 1'b0;

      // R10 latency independent of data
      v = VECS[0];
      run(mk_insn(v), v.sp);
      lat0 = g_cycles;
      key = 64'hFFFF_0000_5555_AAAA;
      check_vec(v, "R10 new data");
      chk(g_cycles == lat0, "R10 same latency with new data", 64'(g_cycles), 64'(lat0));

      @(negedge clk);
      chk(insn_ready && !exc_valid, "R1 idle at end", 64'(insn_ready), 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule